// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

This is a per-core timer that raises an interrupt request after a programmed delay. It offers three operating modes. In one-shot mode the timer counts down once. In periodic mode it counts down over and over. In deadline mode it compares a 64-bit timestamp, which runs freely, against an absolute target value. A 2-bit field in the timer's vector entry selects the mode. The same entry also holds the 8-bit interrupt vector and a mask bit. A prescale field sets how fast the countdown advances.

Software uses a simple register port. A write takes effect on the clock edge where `reg_we` is high. A read is combinational on `reg_addr`. Register map: 0 = vector entry, 1 = initial count, 2 = current count (read only), 3 = divide, 4 = deadline, 5 = timestamp (read only). Addresses 6 and 7 read as zero. When the timer expires, the block drives a one-cycle request that carries the programmed vector. Delivery and prioritisation of that request are handled elsewhere.

Top module: `irq_timer_top`

## Requirements
- R1: The vector entry keeps only bits 7:0 (vector), bit 16 (mask) and the mode field at bits 18:17. Mode encodings: 00 one-shot, 01 periodic, 10 deadline. With DEADLINE_EN=0 only bit 17 of the mode field is kept. All other bits read as 0. The entry resets to 0x0001_0000, which is masked.
- R2: An entry write made while `sw_enable` is low is stored with bit 16 forced to 1.
- R3: An entry write that changes the stored mode field cancels any armed countdown or deadline. An entry write that leaves the mode unchanged does not disturb a running countdown.
- R4: In one-shot mode, writing a nonzero initial count N arms the countdown. Exactly one request appears N×2^d cycles after the write edge, and the current count then reads 0.
- R5: Divide register bits 2:0 hold d, which gives a prescale of 2^d (from 1 to 128). While the countdown runs, the current count reads the remaining cycles divided by 2^d.
- R6: Writing an initial count of 0 in a counting mode stores 0 and leaves the timer stopped.
- R7: In periodic mode, the countdown reloads on each expiry, so requests repeat every N×2^d cycles.
- R8: In periodic mode, a countdown length below MIN_PERIOD (default 16, and at least 2) is raised to MIN_PERIOD.
- R9: In deadline mode, the current count reads 0 and writes to the initial count are ignored (its stored value stays the same).
- R10: In one-shot or periodic mode, the deadline register reads 0 and writes to it are ignored.
- R11: In deadline mode, writing D replaces the pending deadline. Take t0 as the timestamp during the write cycle. The request appears max(D−t0,1) cycles after the write edge. D=0 disarms the timer without a request.
- R12: A request is a one-cycle pulse on `irq_valid`, with `irq_vector` equal to entry bits 7:0. An expiry while bit 16 is set produces no pulse.
- R13: The timestamp at address 5 increases by one on every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_enable | input | 1 | Unit software-enable; when low, entry writes are forced masked |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both write and read |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
If the internal state is wrong, the fault shows at the ports as a request that arrives at the wrong cycle, a request that is missing, or a request that repeats. The bench therefore measures the distance from each arming write to the pulse, and it must match to the exact cycle. A stale mode or a failed cancel shows up within one countdown length, as a pulse where none is expected. A corrupted register shows up on the next read, through masked readback (zero current count, zero deadline) or through unchanged stored values.

// File: rtl/irq_timer_pkg.sv
`timescale 1ns/1ps
package irq_timer_pkg;

  typedef enum logic [1:0] {
    TM_ONESHOT  = 2'b00,
    TM_PERIODIC = 2'b01,
    TM_DEADLINE = 2'b10,
    TM_RESERVED = 2'b11
  } tmode_e;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned DIV_W  = 3;

  localparam logic [ADDR_W-1:0] A_ENTRY    = 3'd0;
  localparam logic [ADDR_W-1:0] A_ICOUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CURRENT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIVIDE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DEADLINE = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAMP    = 3'd5;

  localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;
  localparam logic [31:0] ENTRY_MASKB = 32'h0001_0000;
  localparam logic [31:0] ENTRY_BASE  = 32'h0001_00FF;

endpackage

// File: rtl/irq_timer_entry.sv
`timescale 1ns/1ps
module irq_timer_entry
  import irq_timer_pkg::*;
#(
  parameter bit DEADLINE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        sw_enable_i,
  output logic [31:0] entry_o,
  output logic [7:0]  vector_o,
  output logic        mask_o,
  output tmode_e      mode_o,
  output logic        mode_change_o
);

  localparam logic [31:0] MODE_MASK = DEADLINE_EN ? 32'h0006_0000 : 32'h0002_0000;
  localparam logic [31:0] KEEP_MASK = ENTRY_BASE | MODE_MASK;

  logic [31:0] entry_q;
  logic [31:0] entry_n;

  always_comb begin
    entry_n = (wdata_i & KEEP_MASK) | (sw_enable_i ? 32'h0 : ENTRY_MASKB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RESET;
    end else if (we_i) begin
      entry_q <= entry_n;
    end
  end

  assign mode_change_o = we_i && ((wdata_i & MODE_MASK) != (entry_q & MODE_MASK));
  assign entry_o       = entry_q;
  assign vector_o      = entry_q[7:0];
  assign mask_o        = entry_q[16];
  assign mode_o        = tmode_e'(entry_q[18:17]);

  assert_kept_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_q & ~KEEP_MASK) == 32'h0);

  assert_forced_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sw_enable_i) |=> mask_o);

endmodule

// File: rtl/irq_timer_countdown.sv
`timescale 1ns/1ps
module irq_timer_countdown
  import irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MIN_PERIOD = 16,
  localparam int unsigned LEN_W     = CNT_W + (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             cancel_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DIV_W-1:0] shift_i,
  input  logic             periodic_i,
  output logic             expire_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] remain_o
);

  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_PERIOD);

  logic             run_q, run_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [DIV_W-1:0] sh_q, sh_n;
  logic [LEN_W-1:0] len_raw, len_arm;
  logic             upd_en;

  always_comb begin
    len_raw = LEN_W'(count_i) << shift_i;
    len_arm = (periodic_i && (len_raw < MIN_LEN)) ? MIN_LEN : len_raw;
  end

  always_comb begin
    run_n    = run_q;
    rem_n    = rem_q;
    len_n    = len_q;
    sh_n     = sh_q;
    expire_o = 1'b0;
    if (cancel_i) begin
      run_n = 1'b0;
      rem_n = '0;
    end else if (arm_i) begin
      if (count_i == '0) begin
        run_n = 1'b0;
        rem_n = '0;
      end else begin
        run_n = 1'b1;
        rem_n = len_arm;
        len_n = len_arm;
        sh_n  = shift_i;
      end
    end else if (run_q) begin
      if (rem_q == LEN_W'(1)) begin
        expire_o = 1'b1;
        if (periodic_i) begin
          rem_n = len_q;
        end else begin
          run_n = 1'b0;
          rem_n = '0;
        end
      end else begin
        rem_n = rem_q - LEN_W'(1);
      end
    end
  end

  assign upd_en = cancel_i | arm_i | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rem_q <= '0;
      len_q <= '0;
      sh_q  <= '0;
    end else if (upd_en) begin
      run_q <= run_n;
      rem_q <= rem_n;
      len_q <= len_n;
      sh_q  <= sh_n;
    end
  end

  assign busy_o   = run_q;
  assign remain_o = CNT_W'(rem_q >> sh_q);

  assert_oneshot_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !periodic_i) |=> !busy_o);

  assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && periodic_i) |=> (busy_o && (rem_q > LEN_W'(1))));

  assert_period_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && periodic_i) |-> (len_q >= MIN_LEN));

endmodule

// File: rtl/irq_timer_deadline.sv
`timescale 1ns/1ps
module irq_timer_deadline
  import irq_timer_pkg::*;
#(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [TS_W-1:0] wdata_i,
  input  logic            cancel_i,
  output logic            expire_o,
  output logic [TS_W-1:0] deadline_o,
  output logic [TS_W-1:0] stamp_o
);

  logic [TS_W-1:0] ts_q, ts_n;
  logic [TS_W-1:0] dl_q, dl_n;
  logic            arm_q, arm_n;
  logic            upd_en;

  always_comb begin
    ts_n     = ts_q + TS_W'(1);
    dl_n     = dl_q;
    arm_n    = arm_q;
    expire_o = arm_q && (ts_q >= dl_q) && !we_i && !cancel_i;
    if (cancel_i) begin
      arm_n = 1'b0;
    end else if (we_i) begin
      dl_n  = wdata_i;
      arm_n = (wdata_i != '0);
    end else if (expire_o) begin
      arm_n = 1'b0;
    end
  end

  assign upd_en = cancel_i | we_i | arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0;
    end else begin
      ts_q <= ts_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q  <= '0;
      arm_q <= 1'b0;
    end else if (upd_en) begin
      dl_q  <= dl_n;
      arm_q <= arm_n;
    end
  end

  assign deadline_o = dl_q;
  assign stamp_o    = ts_q;

  assert_disarm_after_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !arm_q);

  assert_zero_disarms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !cancel_i && (wdata_i == '0)) |=> !arm_q);

  assert_stamp_advances_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ts_q == $past(ts_q) + TS_W'(1)));

endmodule

// File: rtl/irq_timer_top.sv
`timescale 1ns/1ps
module irq_timer_top
  import irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned MIN_PERIOD  = 16,
  parameter bit          DEADLINE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_enable,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        irq_valid,
  output logic [7:0]  irq_vector
);

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s = rst_sync_q[1];

  logic [31:0] entry_w;
  logic [7:0]  vec_w;
  logic        mask_w;
  tmode_e      mode_w;
  logic        cancel_w;

  logic             wr_entry, wr_icount, wr_divide, wr_deadline;
  logic             is_dl, is_cd, is_per;
  logic [CNT_W-1:0] icount_q, icount_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic             icount_en, div_en;
  logic             cd_arm, cd_exp, cd_busy;
  logic [CNT_W-1:0] cd_remain;
  logic             dl_we, dl_exp;
  logic [63:0]      dl_value, stamp;
  logic             irq_q, irq_n;
  logic [7:0]       vec_q, vec_n;

  assign wr_entry    = reg_we && (reg_addr == A_ENTRY);
  assign wr_icount   = reg_we && (reg_addr == A_ICOUNT);
  assign wr_divide   = reg_we && (reg_addr == A_DIVIDE);
  assign wr_deadline = reg_we && (reg_addr == A_DEADLINE);

  assign is_dl  = (mode_w == TM_DEADLINE);
  assign is_per = (mode_w == TM_PERIODIC);
  assign is_cd  = (mode_w == TM_ONESHOT) || is_per;

  irq_timer_entry #(.DEADLINE_EN(DEADLINE_EN)) u_entry (
    .clk          (clk),
    .rst_n        (rst_s),
    .we_i         (wr_entry),
    .wdata_i      (reg_wdata[31:0]),
    .sw_enable_i  (sw_enable),
    .entry_o      (entry_w),
    .vector_o     (vec_w),
    .mask_o       (mask_w),
    .mode_o       (mode_w),
    .mode_change_o(cancel_w)
  );

  always_comb begin
    icount_n  = reg_wdata[CNT_W-1:0];
    icount_en = wr_icount && !is_dl;
    div_n     = reg_wdata[DIV_W-1:0];
    div_en    = wr_divide;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      icount_q <= '0;
    end else if (icount_en) begin
      icount_q <= icount_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_n;
    end
  end

  assign cd_arm = wr_icount && is_cd;
  assign dl_we  = wr_deadline && is_dl;

  irq_timer_countdown #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_count (
    .clk       (clk),
    .rst_n     (rst_s),
    .arm_i     (cd_arm),
    .cancel_i  (cancel_w),
    .count_i   (icount_n),
    .shift_i   (div_q),
    .periodic_i(is_per),
    .expire_o  (cd_exp),
    .busy_o    (cd_busy),
    .remain_o  (cd_remain)
  );

  irq_timer_deadline #(.TS_W(64)) u_dead (
    .clk       (clk),
    .rst_n     (rst_s),
    .we_i      (dl_we),
    .wdata_i   (reg_wdata),
    .cancel_i  (cancel_w),
    .expire_o  (dl_exp),
    .deadline_o(dl_value),
    .stamp_o   (stamp)
  );

  always_comb begin
    irq_n = (cd_exp || dl_exp) && !mask_w;
    vec_n = vec_w;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_n;
      vec_q <= vec_n;
    end
  end

  assign irq_valid  = irq_q;
  assign irq_vector = vec_q;

  always_comb begin
    case (reg_addr)
      A_ENTRY:    reg_rdata = {32'h0, entry_w};
      A_ICOUNT:   reg_rdata = 64'(icount_q);
      A_CURRENT:  reg_rdata = is_dl ? 64'h0 : 64'(cd_remain);
      A_DIVIDE:   reg_rdata = 64'(div_q);
      A_DEADLINE: reg_rdata = is_dl ? dl_value : 64'h0;
      A_STAMP:    reg_rdata = stamp;
      default:    reg_rdata = 64'h0;
    endcase
  end

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_s)
    irq_valid |=> !irq_valid);

  assert_no_count_in_deadline_R9: assert property (@(posedge clk) disable iff (!rst_s)
    is_dl |-> !cd_busy);

  assert_cancel_stops_R3: assert property (@(posedge clk) disable iff (!rst_s)
    cancel_w |=> !cd_busy);

endmodule

// File: tb/irq_timer_top_test.sv
`timescale 1ns/1ps
module irq_timer_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_enable;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata, rdata_b;
  logic        irq_valid, irq_b;
  logic [7:0]  irq_vector, vec_b;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] seen_vec;

  always #2 clk = ~clk;

  irq_timer_top #(.CNT_W(32), .MIN_PERIOD(16), .DEADLINE_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  irq_timer_top #(.CNT_W(32), .MIN_PERIOD(16), .DEADLINE_EN(1'b0)) uut_nodl (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
    .irq_valid(irq_b), .irq_vector(vec_b)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Call at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // Cycles after the last write edge until irq_valid; limit+1 if none.
  task automatic wait_irq(input int limit, output int m);
    m = 0;
    while (m <= limit && !irq_valid) begin
      @(negedge clk);
      m++;
    end
    seen_vec = irq_vector;
  endtask

  task automatic wait_next(input int limit, output int m);
    m = 0;
    do begin
      @(negedge clk);
      m++;
    end while (m <= limit && !irq_valid);
    seen_vec = irq_vector;
  endtask

  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_valid) hits++;
    end
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(3'd0, v); check("R1 reset entry", v, 64'h0001_0000);
    rd(3'd2, v); check("R4 reset current", v, 0);
    rd(3'd1, v); check("R9 reset icount", v, 0);
    check("R12 reset irq", irq_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_entry_bits;
    logic [63:0] v;
    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd0, v); check("R1 kept bits", v, 64'h0007_00FF);
    reg_addr = 3'd0; #1;
    check("R1 kept bits, no deadline", rdata_b, 64'h0003_00FF);
    @(negedge clk);
    sw_enable = 1'b0;
    wr(3'd0, 64'h0000_0021);
    rd(3'd0, v); check("R2 forced mask", v, 64'h0001_0021);
    sw_enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_oneshot;
    int m, h;
    logic [63:0] v;
    wr(3'd0, 64'h0000_0011);
    wr(3'd3, 64'd0);
    wr(3'd1, 64'd5);
    wait_irq(40, m); check("R4 oneshot delay", m, 5);
    check("R12 vector", seen_vec, 8'h11);
    quiet(40, h); check("R4 single request", h, 0);
    rd(3'd2, v); check("R4 current after expiry", v, 0);
    @(negedge clk);
  endtask

  task automatic t_divide;
    int m;
    logic [63:0] v;
    wr(3'd3, 64'd2);
    wr(3'd1, 64'd3);
    wait_irq(60, m); check("R5 divide by 4", m, 12);
    @(negedge clk);
    wr(3'd1, 64'd10);
    rd(3'd2, v); check("R5 current at start", v, 10);
    repeat (8) @(negedge clk);
    rd(3'd2, v); check("R5 current after 8", v, 8);
    wait_irq(60, m); check("R5 remaining wait", m, 32);
    @(negedge clk);
    wr(3'd3, 64'd0);
  endtask

  task automatic t_periodic;
    int m, h;
    logic [63:0] v;
    wr(3'd0, 64'h0002_0022);
    wr(3'd1, 64'd20);
    wait_irq(60, m); check("R7 first period", m, 20);
    wait_next(60, m); check("R7 second period", m, 20);
    wait_next(60, m); check("R7 third period", m, 20);
    @(negedge clk);
    wr(3'd1, 64'd0);
    quiet(60, h); check("R6 zero count stops", h, 0);
    rd(3'd2, v); check("R6 current zero", v, 0);
    @(negedge clk);
    wr(3'd1, 64'd2);
    wait_irq(60, m); check("R8 clamped first", m, 16);
    wait_next(60, m); check("R8 clamped period", m, 16);
    @(negedge clk);
  endtask

  task automatic t_cancel;
    int m, h;
    wr(3'd0, 64'h0000_0031);
    wr(3'd1, 64'd30);
    repeat (10) @(negedge clk);
    wr(3'd0, 64'h0002_0031);
    quiet(50, h); check("R3 mode change cancels", h, 0);
    wr(3'd0, 64'h0000_0031);
    wr(3'd1, 64'd30);
    repeat (10) @(negedge clk);
    wr(3'd0, 64'h0000_0033);
    wait_irq(40, m); check("R3 same mode keeps running", m, 19);
    check("R12 vector after rewrite", seen_vec, 8'h33);
    @(negedge clk);
  endtask

  task automatic t_mask;
    int h;
    wr(3'd0, 64'h0001_0044);
    wr(3'd1, 64'd5);
    quiet(30, h); check("R12 masked expiry", h, 0);
  endtask

  task automatic t_deadline;
    int m, h;
    logic [63:0] v, t0, last_dl;
    wr(3'd0, 64'h0004_0040);
    rd(3'd2, v); check("R9 current reads zero", v, 0);
    @(negedge clk);
    rd(3'd1, t0);
    @(negedge clk);
    wr(3'd1, 64'd77);
    rd(3'd1, v); check("R9 icount write ignored", v, t0);
    quiet(30, h); check("R9 no countdown", h, 0);
    rd(3'd5, t0);
    wr(3'd4, t0 + 20);
    wait_irq(60, m); check("R11 future deadline", m, 20);
    check("R12 deadline vector", seen_vec, 8'h40);
    @(negedge clk);
    wr(3'd4, 64'd1);
    wait_irq(20, m); check("R11 past deadline", m, 1);
    @(negedge clk);
    rd(3'd5, t0);
    wr(3'd4, t0 + 15);
    wr(3'd4, 64'd0);
    quiet(40, h); check("R11 zero disarms", h, 0);
    rd(3'd5, t0);
    wr(3'd4, t0 + 40);
    rd(3'd5, t0);
    last_dl = t0 + 10;
    wr(3'd4, last_dl);
    rd(3'd4, v); check("R11 deadline readback", v, last_dl);
    wait_irq(60, m); check("R11 rewrite replaces", m, 10);
    quiet(50, h); check("R11 old deadline dropped", h, 0);
    wr(3'd0, 64'h0000_0040);
    rd(3'd4, v); check("R10 deadline reads zero", v, 0);
    @(negedge clk);
    wr(3'd4, 64'd999);
    wr(3'd0, 64'h0004_0040);
    rd(3'd4, v); check("R10 deadline write ignored", v, last_dl);
    quiet(20, h); check("R10 no arm from ignored write", h, 0);
  endtask

  task automatic t_nodl;
    int m;
    wr(3'd0, 64'h0004_0010);
    reg_addr = 3'd0; #1;
    check("R1 mode bit 18 dropped", rdata_b, 64'h0000_0010);
    @(negedge clk);
    wr(3'd1, 64'd5);
    m = 0;
    while (m <= 20 && !irq_b) begin
      @(negedge clk);
      m++;
    end
    check("R1 no-deadline unit counts", m, 5);
    @(negedge clk);
  endtask

  task automatic t_stamp;
    logic [63:0] a, b;
    rd(3'd5, a);
    repeat (10) @(negedge clk);
    rd(3'd5, b);
    check("R13 timestamp advance", b - a, 10);
  endtask

  initial begin
    #300000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw_enable = 1'b1; reg_we = 1'b0;
    reg_addr = 3'd0; reg_wdata = 64'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_entry_bits();
    t_oneshot();
    t_divide();
    t_periodic();
    t_cancel();
    t_mask();
    t_deadline();
    t_nodl();
    t_stamp();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule